// File: doc/BRIEF.md
# Single-Bit Memory Operation and Bit-Test Branch Unit

This unit is the execution slice of an 8-bit processor core that handles the instructions working on individual bits and bit masks of a memory byte. It clears or sets one bit of a zero-page byte, tests one bit and decides a conditional branch, and performs the mask-based test-and-set and test-and-clear operations. It also evaluates the bit-test instruction against the accumulator.

The surrounding core has already fetched the operand byte from memory, the relative offset byte and the address that follows the offset byte. It presents them together with the opcode and a valid strobe. One clock later the unit returns registered results: a write-back byte with its enable, flag updates with their enables, a branch decision with the branch target, and the instruction's cycle count for the sequencer. Instruction fetch and bus timing are left to the core.

Top module: `bit_manip_unit`

## Requirements
- R1: During and directly after a synchronous reset, res_valid_o, wr_en_o, z_we_o, nv_we_o and br_taken_o are all 0.
- R2: An opcode with low nibble 0x7 and bit 7 clear clears memory bit opcode[6:4]: wr_en_o is 1, wr_data_o equals the operand with only that bit forced to 0, and no flag enable is raised.
- R3: An opcode with low nibble 0x7 and bit 7 set sets memory bit opcode[6:4]: wr_en_o is 1, wr_data_o equals the operand with only that bit forced to 1, and no flag enable is raised.
- R4: An opcode with low nibble 0xF tests operand bit opcode[6:4]; with opcode bit 7 clear the branch is taken when that bit is 0, with opcode bit 7 set when it is 1. No write and no flag update occurs.
- R5: br_target_o equals pc_i plus the sign-extended offset rel_i, modulo 0x10000, where pc_i is the address after the offset byte.
- R6: Test-and-set (0x04 zero-page, 0x0C absolute) writes operand OR accumulator and sets Z to 1 exactly when operand AND accumulator is 0; N and V are not updated.
- R7: Test-and-clear (0x14 zero-page, 0x1C absolute) writes operand AND NOT accumulator, with the same Z rule as R6 and no N or V update.
- R8: Bit-test in immediate form (0x89) updates only Z (operand AND accumulator equals 0). In the forms 0x24, 0x2C, 0x34 and 0x3C it also updates N from operand bit 7 and V from operand bit 6. It never writes memory.
- R9: cycles_o reports 5 for bit clear/set and bit branches, 5 for zero-page and 6 for absolute test-and-set/clear, and 2, 3, 4, 4, 4 for bit-test at 0x89, 0x24, 0x34, 0x2C, 0x3C.
- R10: Results appear with res_valid_o exactly one clock after op_valid_i is sampled high with a handled opcode; an unhandled opcode raises no valid and no enable.
- R11: With op_valid_i low, no valid and no enable is raised, and back-to-back operations in consecutive cycles each produce their own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation inputs are valid this cycle |
| opcode_i | input | 8 | Instruction opcode |
| mem_i | input | 8 | Operand byte read from memory (or immediate) |
| acc_i | input | 8 | Accumulator value |
| rel_i | input | 8 | Signed branch offset byte |
| pc_i | input | 16 | Address of the byte after the offset byte |
| res_valid_o | output | 1 | Registered result is valid |
| wr_en_o | output | 1 | Write wr_data_o back to the operand address |
| wr_data_o | output | 8 | Write-back byte |
| z_we_o | output | 1 | Z flag update enable |
| z_o | output | 1 | New Z flag |
| nv_we_o | output | 1 | N and V flag update enable |
| n_o | output | 1 | New N flag |
| v_o | output | 1 | New V flag |
| br_taken_o | output | 1 | Bit branch is taken |
| br_target_o | output | 16 | Branch target address |
| cycles_o | output | 3 | Cycle count of the instruction |

## Verification
The memory write-back and the Z flag update fall in the same result cycle for test-and-set and test-and-clear, and both must agree with one operand/accumulator pair. The bench provokes this with mask pairs that do and do not overlap, so both the written byte and the Z value are judged at once against values computed from R6 and R7. A second overlap is a bit branch issued in the cycle right after a test-and-set: the bench checks that the branch result carries no write and no flag update while the previous result was a write with Z.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  localparam int unsigned OPC_W = 8;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned CYC_W = 3;

  typedef enum logic [2:0] {
    K_NONE,
    K_CLRBIT,
    K_SETBIT,
    K_BRCLR,
    K_BRSET,
    K_TSET,
    K_TCLR,
    K_BTEST
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [IDX_W-1:0]  bit_idx;
    logic              imm;
    logic [CYC_W-1:0]  cycles;
  } dec_t;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output dec_t             dec_o
);

  localparam logic [3:0] NIB_BITMOD = 4'h7;
  localparam logic [3:0] NIB_BITBR  = 4'hF;

  always_comb begin
    dec_o         = '0;
    dec_o.kind    = K_NONE;
    dec_o.bit_idx = opcode_i[6:4];
    dec_o.imm     = 1'b0;
    dec_o.cycles  = '0;
    if (opcode_i[3:0] == NIB_BITMOD) begin
      dec_o.kind   = opcode_i[7] ? K_SETBIT : K_CLRBIT;
      dec_o.cycles = 3'd5;
    end else if (opcode_i[3:0] == NIB_BITBR) begin
      dec_o.kind   = opcode_i[7] ? K_BRSET : K_BRCLR;
      dec_o.cycles = 3'd5;
    end else begin
      case (opcode_i)
        8'h04: begin dec_o.kind = K_TSET;  dec_o.cycles = 3'd5; end
        8'h0C: begin dec_o.kind = K_TSET;  dec_o.cycles = 3'd6; end
        8'h14: begin dec_o.kind = K_TCLR;  dec_o.cycles = 3'd5; end
        8'h1C: begin dec_o.kind = K_TCLR;  dec_o.cycles = 3'd6; end
        8'h89: begin dec_o.kind = K_BTEST; dec_o.cycles = 3'd2; dec_o.imm = 1'b1; end
        8'h24: begin dec_o.kind = K_BTEST; dec_o.cycles = 3'd3; end
        8'h2C: begin dec_o.kind = K_BTEST; dec_o.cycles = 3'd4; end
        8'h34: begin dec_o.kind = K_BTEST; dec_o.cycles = 3'd4; end
        8'h3C: begin dec_o.kind = K_BTEST; dec_o.cycles = 3'd4; end
        default: begin dec_o.kind = K_NONE; dec_o.cycles = '0; end
      endcase
    end
  end

endmodule

// File: rtl/bmu_bitops.sv
module bmu_bitops
  import bmu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  kind_e             kind_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              imm_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              z_we_o,
  output logic              z_o,
  output logic              nv_we_o,
  output logic              n_o,
  output logic              v_o,
  output logic              sel_bit_o
);

  logic [DATA_W-1:0] onehot;
  logic [DATA_W-1:0] overlap;

  // one-hot mask of the addressed bit
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign onehot[g] = (bit_idx_i == g[IDX_W-1:0]);
  end

  assign overlap   = mem_i & acc_i;
  assign sel_bit_o = |(mem_i & onehot);

  always_comb begin
    wr_en_o   = 1'b0;
    wr_data_o = mem_i;
    z_we_o    = 1'b0;
    z_o       = ~|overlap;
    nv_we_o   = 1'b0;
    n_o       = mem_i[DATA_W-1];
    v_o       = mem_i[DATA_W-2];
    case (kind_i)
      K_CLRBIT: begin
        wr_en_o   = 1'b1;
        wr_data_o = mem_i & ~onehot;
      end
      K_SETBIT: begin
        wr_en_o   = 1'b1;
        wr_data_o = mem_i | onehot;
      end
      K_TSET: begin
        wr_en_o   = 1'b1;
        wr_data_o = mem_i | acc_i;
        z_we_o    = 1'b1;
      end
      K_TCLR: begin
        wr_en_o   = 1'b1;
        wr_data_o = mem_i & ~acc_i;
        z_we_o    = 1'b1;
      end
      K_BTEST: begin
        z_we_o  = 1'b1;
        nv_we_o = ~imm_i;
      end
      default: ;
    endcase
  end

  // R2: a bit clear touches at most one bit and never sets one
  always_comb begin
    if (kind_i == K_CLRBIT) begin
      a_r2_single_clear: assert (($countones(mem_i ^ wr_data_o) <= 1) &&
                                 ((wr_data_o & ~mem_i) == '0));
    end
  end

  // R3: a bit set touches at most one bit and never clears one
  always_comb begin
    if (kind_i == K_SETBIT) begin
      a_r3_single_set: assert (($countones(mem_i ^ wr_data_o) <= 1) &&
                               ((mem_i & ~wr_data_o) == '0));
    end
  end

endmodule

// File: rtl/bmu_branch.sv
module bmu_branch
  import bmu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  kind_e             kind_i,
  input  logic              sel_bit_i,
  input  logic [DATA_W-1:0] rel_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);

  localparam int unsigned EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] rel_ext;

  assign rel_ext  = {{EXT_W{rel_i[DATA_W-1]}}, rel_i};
  assign target_o = pc_i + rel_ext;

  always_comb begin
    case (kind_i)
      K_BRCLR: taken_o = ~sel_bit_i;
      K_BRSET: taken_o =  sel_bit_i;
      default: taken_o = 1'b0;
    endcase
  end

  // R4: only bit-branch kinds may take a branch
  always_comb begin
    if (taken_o) begin
      a_r4_taken_kind: assert ((kind_i == K_BRCLR) || (kind_i == K_BRSET));
    end
  end

endmodule

// File: rtl/bit_manip_unit.sv
module bit_manip_unit
  import bmu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] rel_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              res_valid_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              z_we_o,
  output logic              z_o,
  output logic              nv_we_o,
  output logic              n_o,
  output logic              v_o,
  output logic              br_taken_o,
  output logic [ADDR_W-1:0] br_target_o,
  output logic [2:0]        cycles_o
);

  dec_t              dec;
  logic              hit;
  logic              c_wr_en;
  logic [DATA_W-1:0] c_wr_data;
  logic              c_z_we;
  logic              c_z;
  logic              c_nv_we;
  logic              c_n;
  logic              c_v;
  logic              c_sel_bit;
  logic              c_taken;
  logic [ADDR_W-1:0] c_target;

  bmu_decode u_dec (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  bmu_bitops #(.DATA_W(DATA_W)) u_ops (
    .kind_i    (dec.kind),
    .bit_idx_i (dec.bit_idx),
    .imm_i     (dec.imm),
    .mem_i     (mem_i),
    .acc_i     (acc_i),
    .wr_en_o   (c_wr_en),
    .wr_data_o (c_wr_data),
    .z_we_o    (c_z_we),
    .z_o       (c_z),
    .nv_we_o   (c_nv_we),
    .n_o       (c_n),
    .v_o       (c_v),
    .sel_bit_o (c_sel_bit)
  );

  bmu_branch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_br (
    .kind_i    (dec.kind),
    .sel_bit_i (c_sel_bit),
    .rel_i     (rel_i),
    .pc_i      (pc_i),
    .taken_o   (c_taken),
    .target_o  (c_target)
  );

  assign hit = op_valid_i && (dec.kind != K_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_data_o   <= '0;
      z_we_o      <= 1'b0;
      z_o         <= 1'b0;
      nv_we_o     <= 1'b0;
      n_o         <= 1'b0;
      v_o         <= 1'b0;
      br_taken_o  <= 1'b0;
      br_target_o <= '0;
      cycles_o    <= '0;
    end else begin
      res_valid_o <= hit;
      wr_en_o     <= hit && c_wr_en;
      z_we_o      <= hit && c_z_we;
      nv_we_o     <= hit && c_nv_we;
      br_taken_o  <= hit && c_taken;
      if (hit) begin
        wr_data_o   <= c_wr_data;
        z_o         <= c_z;
        n_o         <= c_n;
        v_o         <= c_v;
        br_target_o <= c_target;
        cycles_o    <= dec.cycles;
      end
    end
  end

  // R10: every enable belongs to a valid result
  a_r10_enables_need_valid: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o || z_we_o || nv_we_o || br_taken_o) |-> res_valid_o);

  // R10/R11: a result follows a sampled request by exactly one clock
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> $past(op_valid_i));

  // R4: a taken branch neither writes nor updates flags
  a_r4_branch_quiet: assert property (@(posedge clk) disable iff (rst)
    br_taken_o |-> (!wr_en_o && !z_we_o && !nv_we_o));

  // R8: N/V updates only come together with a Z update and no write
  a_r8_nv_with_z: assert property (@(posedge clk) disable iff (rst)
    nv_we_o |-> (z_we_o && !wr_en_o));

  // R6/R7: write with Z means the accumulator mask was fully set or fully cleared
  a_r6_r7_mask_applied: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && z_we_o) |->
      (((wr_data_o & $past(acc_i)) == $past(acc_i)) ||
       ((wr_data_o & $past(acc_i)) == '0)));

  // R9: cycle counts stay in the range the instruction set uses
  a_r9_cycle_range: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> ((cycles_o >= 3'd2) && (cycles_o <= 3'd6)));

endmodule

// File: tb/sim_bit_manip_unit.sv
`timescale 1ns/1ps
module sim_bit_manip_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic [7:0]  mem_i = 8'h00;
  logic [7:0]  acc_i = 8'h00;
  logic [7:0]  rel_i = 8'h00;
  logic [15:0] pc_i = 16'h0000;
  logic        res_valid_o, wr_en_o, z_we_o, z_o, nv_we_o, n_o, v_o, br_taken_o;
  logic [7:0]  wr_data_o;
  logic [15:0] br_target_o;
  logic [2:0]  cycles_o;

  int n_checks = 0;
  int n_fails  = 0;
  int n_cyc    = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bit_manip_unit u0 (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .opcode_i(opcode_i),
    .mem_i(mem_i), .acc_i(acc_i), .rel_i(rel_i), .pc_i(pc_i),
    .res_valid_o(res_valid_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
    .z_we_o(z_we_o), .z_o(z_o), .nv_we_o(nv_we_o), .n_o(n_o), .v_o(v_o),
    .br_taken_o(br_taken_o), .br_target_o(br_target_o), .cycles_o(cycles_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // apply one operation; return 1 ns after the capturing edge
  task automatic issue(input logic [7:0] op, input logic [7:0] m, input logic [7:0] a,
                       input logic [7:0] r, input logic [15:0] pc);
    op_valid_i = 1'b1; opcode_i = op; mem_i = m; acc_i = a; rel_i = r; pc_i = pc;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    op_valid_i = 1'b0;
    @(posedge clk); #1;
  endtask

  function automatic logic [15:0] tgt(input logic [15:0] pc, input logic [7:0] r);
    return pc + {{8{r[7]}}, r};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 strobes in reset", {res_valid_o, wr_en_o, z_we_o, nv_we_o, br_taken_o}, 5'b0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 strobes after reset", {res_valid_o, wr_en_o, z_we_o, nv_we_o, br_taken_o}, 5'b0);
  endtask

  task automatic t_clrbit();
    for (int i = 0; i < 8; i++) begin
      issue({1'b0, i[2:0], 4'h7}, 8'hFF, 8'h00, 8'h00, 16'h0000);
      chk($sformatf("R2 clear bit %0d data", i), wr_data_o, 8'hFF & ~(8'h01 << i));
      chk($sformatf("R2 clear bit %0d enables", i),
          {res_valid_o, wr_en_o, z_we_o, nv_we_o, br_taken_o}, 5'b11000);
      chk($sformatf("R9 clear bit %0d cycles", i), cycles_o, 3'd5);
    end
    idle();
  endtask

  task automatic t_setbit();
    for (int i = 0; i < 8; i++) begin
      issue({1'b1, i[2:0], 4'h7}, 8'h24, 8'hFF, 8'h00, 16'h0000);
      chk($sformatf("R3 set bit %0d data", i), wr_data_o, 8'h24 | (8'h01 << i));
      chk($sformatf("R3 set bit %0d enables", i),
          {res_valid_o, wr_en_o, z_we_o, nv_we_o, br_taken_o}, 5'b11000);
    end
    idle();
  endtask

  task automatic t_bitbranch();
    logic [7:0] pat;
    pat = 8'h5A;
    for (int i = 0; i < 16; i++) begin
      logic [2:0] idx;
      logic       want;
      idx  = i[2:0];
      want = (i >= 8) ? pat[idx] : ~pat[idx];
      issue({i[3], idx, 4'hF}, pat, 8'h00, 8'h10, 16'h1234);
      chk($sformatf("R4 bit branch op %0d taken", i), br_taken_o, want);
      chk($sformatf("R4 bit branch op %0d quiet", i), {wr_en_o, z_we_o, nv_we_o}, 3'b0);
      chk($sformatf("R5 bit branch op %0d target", i), br_target_o, 16'h1244);
      chk($sformatf("R9 bit branch op %0d cycles", i), cycles_o, 3'd5);
    end
    idle();
  endtask

  task automatic t_target();
    issue(8'h8F, 8'h01, 8'h00, 8'h20, 16'hFFF0);
    chk("R5 forward wrap", br_target_o, tgt(16'hFFF0, 8'h20));
    chk("R5 forward wrap value", br_target_o, 16'h0010);
    issue(8'h8F, 8'h01, 8'h00, 8'hF0, 16'h0005);
    chk("R5 backward wrap", br_target_o, 16'hFFF5);
    issue(8'h0F, 8'h00, 8'h00, 8'h80, 16'h0100);
    chk("R5 most negative offset", br_target_o, 16'h0080);
    issue(8'h0F, 8'h00, 8'h00, 8'h7F, 16'h0100);
    chk("R5 most positive offset", br_target_o, 16'h017F);
    idle();
  endtask

  task automatic t_testset();
    issue(8'h04, 8'h30, 8'h0C, 8'h00, 16'h0000);
    chk("R6 tset disjoint data", wr_data_o, 8'h3C);
    chk("R6 tset disjoint Z", {wr_en_o, z_we_o, z_o, nv_we_o}, 4'b1110);
    chk("R9 tset zero-page cycles", cycles_o, 3'd5);
    issue(8'h0C, 8'h3C, 8'h0C, 8'h00, 16'h0000);
    chk("R6 tset overlap data", wr_data_o, 8'h3C);
    chk("R6 tset overlap Z", {wr_en_o, z_we_o, z_o, nv_we_o}, 4'b1100);
    chk("R9 tset absolute cycles", cycles_o, 3'd6);
    idle();
  endtask

  task automatic t_testclr();
    issue(8'h14, 8'hFF, 8'h0F, 8'h00, 16'h0000);
    chk("R7 tclr overlap data", wr_data_o, 8'hF0);
    chk("R7 tclr overlap Z", {wr_en_o, z_we_o, z_o, nv_we_o}, 4'b1100);
    chk("R9 tclr zero-page cycles", cycles_o, 3'd5);
    issue(8'h1C, 8'hF0, 8'h0F, 8'h00, 16'h0000);
    chk("R7 tclr disjoint data", wr_data_o, 8'hF0);
    chk("R7 tclr disjoint Z", {wr_en_o, z_we_o, z_o, nv_we_o}, 4'b1110);
    chk("R9 tclr absolute cycles", cycles_o, 3'd6);
    idle();
  endtask

  task automatic t_bittest();
    issue(8'h89, 8'hC0, 8'h3F, 8'h00, 16'h0000);
    chk("R8 immediate Z only", {wr_en_o, z_we_o, z_o, nv_we_o}, 4'b0110);
    chk("R9 immediate cycles", cycles_o, 3'd2);
    issue(8'h2C, 8'hC0, 8'h80, 8'h00, 16'h0000);
    chk("R8 absolute flags", {wr_en_o, z_we_o, z_o, nv_we_o, n_o, v_o}, 6'b010111);
    chk("R9 absolute cycles", cycles_o, 3'd4);
    issue(8'h24, 8'h40, 8'h01, 8'h00, 16'h0000);
    chk("R8 zero-page flags", {z_we_o, z_o, nv_we_o, n_o, v_o}, 5'b11101);
    chk("R9 zero-page cycles", cycles_o, 3'd3);
    issue(8'h34, 8'h80, 8'h80, 8'h00, 16'h0000);
    chk("R8 indexed zero-page flags", {z_we_o, z_o, nv_we_o, n_o, v_o}, 5'b10110);
    chk("R9 indexed zero-page cycles", cycles_o, 3'd4);
    issue(8'h3C, 8'h00, 8'hFF, 8'h00, 16'h0000);
    chk("R8 indexed absolute flags", {z_we_o, z_o, nv_we_o, n_o, v_o}, 5'b11100);
    chk("R9 indexed absolute cycles", cycles_o, 3'd4);
    idle();
  endtask

  task automatic t_ignored();
    issue(8'hEA, 8'hFF, 8'hFF, 8'h10, 16'h2000);
    chk("R10 unhandled opcode", {res_valid_o, wr_en_o, z_we_o, nv_we_o, br_taken_o}, 5'b0);
    op_valid_i = 1'b0; opcode_i = 8'h8F; mem_i = 8'h01;
    @(posedge clk); #1;
    chk("R11 no request no result", {res_valid_o, wr_en_o, z_we_o, nv_we_o, br_taken_o}, 5'b0);
  endtask

  task automatic t_back_to_back();
    issue(8'h04, 8'h01, 8'h02, 8'h00, 16'h4000);
    chk("R11 first of pair write", {res_valid_o, wr_en_o, z_we_o, z_o, br_taken_o}, 5'b11110);
    chk("R11 first of pair data", wr_data_o, 8'h03);
    issue(8'h9F, 8'h02, 8'h00, 8'hFE, 16'h4000);
    chk("R11 second of pair branch", {res_valid_o, wr_en_o, z_we_o, br_taken_o}, 4'b1001);
    chk("R11 second of pair target", br_target_o, 16'h3FFE);
    idle();
    chk("R11 pair drains", res_valid_o, 1'b0);
  endtask

  // watchdog
  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000 && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", n_cyc);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clrbit();
    t_setbit();
    t_bitbranch();
    t_target();
    t_testset();
    t_testclr();
    t_bittest();
    t_ignored();
    t_back_to_back();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule